// File: doc/BRIEF.md
# Link Enable Controller

This block owns the on/off state of a serial display link that carries up to four virtual channels. Software writes through a narrow register port. Selector 0 holds the interface-enable bit. Selectors 1 to 4 hold the per-channel settings: enable, video or command mode, video-port or register source, and automatic bus turn-around after short packets and after long packets. The interface enable and the channel enables can be read back on the outputs.

Turning the link off is graceful. After software writes the enable to 0, the controller keeps the link up and raises `busy` until two conditions hold: the transmit FIFO is empty, and any turn-around it requested has been answered by the peripheral. Only then does the hardware drop the enable. A response timer bounds that wait. If it expires, the wait is forced to end and a sticky timeout flag is set.

When the link is switched on, the controller checks the required video start order. Every channel configured as video mode with the video-port source must already be enabled. If one is not, a sticky sequence-error flag is set and video transfers stay blocked until the next enable.

Top module: `linkEnableCtrl`

## Requirements
- R1: After synchronous reset: `ifEnable`, `chEnable`, `busy`, `btaReq`, `btaPending`, `videoGo`, `seqErr` and `timeoutFlag` are all 0.
- R2: A write with `wrSel`=0 and `wrData[0]`=1 while the link is off raises `ifEnable` at that edge. A write with `wrSel`=k+1 loads channel k as follows: bit0 enable, bit1 video mode, bit2 video-port source, bit3 turn-around after short packets, bit4 turn-around after long packets. `chEnable[k]` shows bit0 from that edge on.
- R3: A write with `wrSel`=0 and `wrData[0]`=0 while the link is on raises `busy` at that edge. `ifEnable` stays 1 as long as `txFifoEmpty` is 0.
- R4: In the draining state, `ifEnable` and `busy` both fall at the first edge at which `txFifoEmpty`=1, no turn-around is pending, and none is being launched.
- R5: `txPktDone` on channel `txPktVc` while the link is up produces a one-cycle `btaReq` at the next edge and sets `btaPending`, but only if the channel is enabled and its matching bit (bit3 for short, bit4 for long) is set. Otherwise nothing is produced.
- R6: While a turn-around is pending, draining does not complete. An `rxRespDone` pulse clears `btaPending`, and the link drops one edge later.
- R7: If a pending turn-around is not answered, it is dropped at the TIMEOUT_CYC-th edge after the disable write and `timeoutFlag` is set. `ifEnable` falls one edge later. The flag is sticky.
- R8: Switching the link on while any channel set to video mode with the video-port source is disabled sets the sticky `seqErr` and keeps `videoGo` at 0 for that enable period.
- R9: `videoGo` is 1 only when the link is up, the last enable passed the order check, and at least one video-port video channel is enabled.
- R10: Writes to selector 0 during draining are ignored: `busy` stays high and completion is unchanged.
- R11: `txPktDone` while the link is off produces no turn-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 3 | Register select: 0 interface, k+1 channel k |
| wrData | input | 5 | Write data |
| txFifoEmpty | input | 1 | Transmit FIFO has no pending data |
| txPktDone | input | 1 | A packet finished transmission |
| txPktLong | input | 1 | Finished packet was long (1) or short (0) |
| txPktVc | input | 2 | Channel of the finished packet |
| rxRespDone | input | 1 | Peripheral response to turn-around received |
| ifEnable | output | 1 | Interface enable readback |
| chEnable | output | 4 | Channel enable readback |
| busy | output | 1 | Graceful disable in progress |
| btaReq | output | 1 | One-cycle turn-around request |
| btaPending | output | 1 | Turn-around awaiting response |
| videoGo | output | 1 | Video transfers permitted |
| seqErr | output | 1 | Sticky enable-order error |
| timeoutFlag | output | 1 | Sticky response timeout |

## Verification
Every result is due exactly one clock edge after its stimulus. This covers the enable, `busy`, `btaReq`, `btaPending` and the flags. The exceptions are the drain completion, which comes one edge after its last condition clears, and the timeout, which fires TIMEOUT_CYC edges after the disable write with the link dropping one edge after that. Inputs are driven on the falling edge and outputs are read at the next falling edge, so each check lands in the cycle the requirement names. The timeout check also confirms that the link is still up one edge before the due cycle.

// File: rtl/linkEnPkg.sv
package linkEnPkg;
  // Channel settings, bit0 = enable .. bit4 = turn-around after long packet
  typedef struct packed {
    logic btaLong;
    logic btaShort;
    logic srcVp;
    logic video;
    logic en;
  } chCfgT;

  typedef enum logic [1:0] {
    LNK_OFF   = 2'd0,
    LNK_ON    = 2'd1,
    LNK_DRAIN = 2'd2
  } lnkStateT;

  // Strobes from control to datapath
  typedef struct packed {
    logic linkUp;
    logic draining;
  } ctrlStrobeT;
endpackage

// File: rtl/linkEnDatapath.sv
module linkEnDatapath
  import linkEnPkg::*;
#(
  parameter int NUM_VC      = 4,
  parameter int TIMEOUT_CYC = 16,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int SEL_W = $clog2(NUM_VC + 1),
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [4:0]        wrData,
  input  logic              txFifoEmpty,
  input  logic              txPktDone,
  input  logic              txPktLong,
  input  logic [VC_W-1:0]   txPktVc,
  input  logic              rxRespDone,
  input  ctrlStrobeT        strobe,
  output logic [NUM_VC-1:0] chEnable,
  output logic              btaReq,
  output logic              btaPending,
  output logic              drainDone,
  output logic              respTimeout,
  output logic              videoMissing,
  output logic              videoReady
);
  chCfgT             cfgQ [NUM_VC];
  logic [NUM_VC-1:0] isVideo;
  logic              btaLaunch;
  logic              pendQ;
  logic              reqQ;
  logic [CNT_W-1:0]  waitCnt;
  chCfgT             pktCfg;

  for (genvar i = 0; i < NUM_VC; i++) begin : g_vc
    always_ff @(posedge clk) begin
      if (rst) cfgQ[i] <= '0;
      else if (wrEn && wrSel == SEL_W'(i + 1)) cfgQ[i] <= chCfgT'(wrData);
    end
    assign chEnable[i] = cfgQ[i].en;
    assign isVideo[i]  = cfgQ[i].video & cfgQ[i].srcVp;
  end

  assign videoMissing = |(isVideo & ~chEnable);
  assign videoReady   = |(isVideo & chEnable);

  always_comb begin
    pktCfg = '0;
    if (int'(txPktVc) < NUM_VC) pktCfg = cfgQ[txPktVc];
  end

  assign btaLaunch = strobe.linkUp & txPktDone & ~pendQ & pktCfg.en &
                     (txPktLong ? pktCfg.btaLong : pktCfg.btaShort);

  assign respTimeout = strobe.draining & pendQ & ~rxRespDone &
                       (waitCnt == CNT_W'(TIMEOUT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      pendQ   <= 1'b0;
      reqQ    <= 1'b0;
      waitCnt <= '0;
    end else begin
      reqQ <= btaLaunch;
      if (btaLaunch) pendQ <= 1'b1;
      else if (rxRespDone || respTimeout) pendQ <= 1'b0;
      if (strobe.draining && pendQ && !respTimeout && !rxRespDone)
        waitCnt <= waitCnt + 1'b1;
      else
        waitCnt <= '0;
    end
  end

  assign btaReq     = reqQ;
  assign btaPending = pendQ;
  assign drainDone  = txFifoEmpty & ~pendQ & ~btaLaunch;
endmodule

// File: rtl/linkEnCtrl.sv
module linkEnCtrl
  import linkEnPkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrlWr,
  input  logic       ctrlBit,
  input  logic       drainDone,
  input  logic       respTimeout,
  input  logic       videoMissing,
  input  logic       videoReady,
  output ctrlStrobeT strobe,
  output logic       ifEnable,
  output logic       busy,
  output logic       videoGo,
  output logic       seqErr,
  output logic       timeoutFlag
);
  lnkStateT stateQ;
  logic     videoBlockQ;
  logic     seqErrQ;
  logic     toutQ;

  always_ff @(posedge clk) begin
    if (rst) begin
      stateQ      <= LNK_OFF;
      videoBlockQ <= 1'b0;
      seqErrQ     <= 1'b0;
      toutQ       <= 1'b0;
    end else begin
      if (respTimeout) toutQ <= 1'b1;
      unique case (stateQ)
        LNK_OFF: if (ctrlWr && ctrlBit) begin
          stateQ      <= LNK_ON;
          videoBlockQ <= videoMissing;
          if (videoMissing) seqErrQ <= 1'b1;
        end
        LNK_ON: if (ctrlWr && !ctrlBit) stateQ <= LNK_DRAIN;
        LNK_DRAIN: if (drainDone) stateQ <= LNK_OFF;
        default: stateQ <= LNK_OFF;
      endcase
    end
  end

  assign ifEnable        = (stateQ != LNK_OFF);
  assign busy            = (stateQ == LNK_DRAIN);
  assign strobe.linkUp   = ifEnable;
  assign strobe.draining = busy;
  assign videoGo         = ifEnable & ~videoBlockQ & videoReady;
  assign seqErr          = seqErrQ;
  assign timeoutFlag     = toutQ;
endmodule

// File: rtl/linkEnableCtrl.sv
module linkEnableCtrl
  import linkEnPkg::*;
#(
  parameter int NUM_VC      = 4,
  parameter int TIMEOUT_CYC = 16,
  localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
  localparam int SEL_W = $clog2(NUM_VC + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [4:0]        wrData,
  input  logic              txFifoEmpty,
  input  logic              txPktDone,
  input  logic              txPktLong,
  input  logic [VC_W-1:0]   txPktVc,
  input  logic              rxRespDone,
  output logic              ifEnable,
  output logic [NUM_VC-1:0] chEnable,
  output logic              busy,
  output logic              btaReq,
  output logic              btaPending,
  output logic              videoGo,
  output logic              seqErr,
  output logic              timeoutFlag
);
  ctrlStrobeT strobe;
  logic drainDone, respTimeout, videoMissing, videoReady;

  linkEnDatapath #(.NUM_VC(NUM_VC), .TIMEOUT_CYC(TIMEOUT_CYC)) u_dp (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .txFifoEmpty(txFifoEmpty), .txPktDone(txPktDone), .txPktLong(txPktLong),
    .txPktVc(txPktVc), .rxRespDone(rxRespDone), .strobe(strobe),
    .chEnable(chEnable), .btaReq(btaReq), .btaPending(btaPending),
    .drainDone(drainDone), .respTimeout(respTimeout),
    .videoMissing(videoMissing), .videoReady(videoReady)
  );

  linkEnCtrl u_ctrl (
    .clk(clk), .rst(rst), .ctrlWr(wrEn && wrSel == '0), .ctrlBit(wrData[0]),
    .drainDone(drainDone), .respTimeout(respTimeout),
    .videoMissing(videoMissing), .videoReady(videoReady), .strobe(strobe),
    .ifEnable(ifEnable), .busy(busy), .videoGo(videoGo), .seqErr(seqErr),
    .timeoutFlag(timeoutFlag)
  );
endmodule

// File: rtl/linkEnChk.sv
module linkEnChk (
  input logic clk,
  input logic rst,
  input logic ifEnable,
  input logic busy,
  input logic btaReq,
  input logic btaPending,
  input logic txPktDone,
  input logic videoGo,
  input logic seqErr,
  input logic timeoutFlag
);
  // R3
  busy_link_up_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> ifEnable);
  // R4
  graceful_drop_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ifEnable) |-> $past(busy));
  // R5
  bta_cause_chk: assert property (@(posedge clk) disable iff (rst)
    btaReq |-> ($past(txPktDone) && btaPending));
  // R5
  bta_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    btaReq |=> !btaReq);
  // R8
  seq_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    seqErr |=> seqErr);
  // R7
  tout_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    timeoutFlag |=> timeoutFlag);
  // R7
  tout_in_drain_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(timeoutFlag) |-> $past(busy));
  // R9
  video_gate_chk: assert property (@(posedge clk) disable iff (rst)
    videoGo |-> ifEnable);
endmodule

bind linkEnableCtrl linkEnChk u_chk (
  .clk(clk), .rst(rst), .ifEnable(ifEnable), .busy(busy), .btaReq(btaReq),
  .btaPending(btaPending), .txPktDone(txPktDone), .videoGo(videoGo),
  .seqErr(seqErr), .timeoutFlag(timeoutFlag)
);

// File: tb/linkEnableCtrl_test.sv
module linkEnableCtrl_test;
  localparam int TOUT = 8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [2:0] wrSel = '0;
  logic [4:0] wrData = '0;
  logic txFifoEmpty = 1'b1, txPktDone = 1'b0, txPktLong = 1'b0, rxRespDone = 1'b0;
  logic [1:0] txPktVc = '0;
  logic ifEnable, busy, btaReq, btaPending, videoGo, seqErr, timeoutFlag;
  logic [3:0] chEnable;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  linkEnableCtrl #(.NUM_VC(4), .TIMEOUT_CYC(TOUT)) uut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .txFifoEmpty(txFifoEmpty), .txPktDone(txPktDone), .txPktLong(txPktLong),
    .txPktVc(txPktVc), .rxRespDone(rxRespDone), .ifEnable(ifEnable),
    .chEnable(chEnable), .busy(busy), .btaReq(btaReq), .btaPending(btaPending),
    .videoGo(videoGo), .seqErr(seqErr), .timeoutFlag(timeoutFlag)
  );

  // {cfg[4:0] = btaLong,btaShort,srcVp,video,en ; vc[1:0] ; long ; expBta}
  localparam logic [8:0] VEC [7] = '{
    {5'b01001, 2'd0, 1'b0, 1'b1},
    {5'b01001, 2'd0, 1'b1, 1'b0},
    {5'b10001, 2'd1, 1'b1, 1'b1},
    {5'b00001, 2'd1, 1'b0, 1'b0},
    {5'b10000, 2'd2, 1'b1, 1'b0},
    {5'b11001, 2'd3, 1'b0, 1'b1},
    {5'b11001, 2'd3, 1'b1, 1'b1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic wr(input logic [2:0] sel, input logic [4:0] d);
    @(negedge clk); wrEn = 1'b1; wrSel = sel; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pkt(input logic [1:0] vc, input logic lng);
    @(negedge clk); txPktDone = 1'b1; txPktVc = vc; txPktLong = lng;
    @(negedge clk); txPktDone = 1'b0;
  endtask

  task automatic resp();
    @(negedge clk); rxRespDone = 1'b1;
    @(negedge clk); rxRespDone = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    step();
    // R1 reset state
    check("R1 ifEnable", ifEnable, 0);
    check("R1 chEnable", chEnable, 0);
    check("R1 busy", busy, 0);
    check("R1 bta", {btaReq, btaPending}, 0);
    check("R1 flags", {videoGo, seqErr, timeoutFlag}, 0);

    // R11 packet while off
    wr(3'd1, 5'b01001);
    pkt(2'd0, 1'b0);
    check("R11 no bta when off", {btaReq, btaPending}, 0);

    // R2 enable, no video channels configured
    wr(3'd0, 5'd1);
    check("R2 ifEnable", ifEnable, 1);
    check("R8 no seqErr", seqErr, 0);

    // R5 vector walk
    foreach (VEC[i]) begin
      wr({1'b0, VEC[i][3:2]} + 3'd1, VEC[i][8:4]);
      check("R2 chEnable readback", chEnable[VEC[i][3:2]], VEC[i][4]);
      pkt(VEC[i][3:2], VEC[i][1]);
      check("R5 btaReq", btaReq, VEC[i][0]);
      check("R5 btaPending", btaPending, VEC[i][0]);
      step();
      check("R5 pulse width", btaReq, 0);
      if (VEC[i][0]) begin
        resp();
        check("R6 response clears", btaPending, 0);
      end
    end

    // R3/R10/R4 drain with FIFO data
    txFifoEmpty = 1'b0;
    wr(3'd0, 5'd0);
    check("R3 busy", busy, 1);
    check("R3 ifEnable held", ifEnable, 1);
    wr(3'd0, 5'd1);
    check("R10 busy kept", busy, 1);
    wr(3'd0, 5'd0);
    check("R10 still draining", {ifEnable, busy}, 2'b11);
    txFifoEmpty = 1'b1;
    step();
    check("R4 link dropped", {ifEnable, busy}, 2'b00);

    // R8 ordering error: channel 2 video/video-port but disabled
    wr(3'd3, 5'b00110);
    wr(3'd0, 5'd1);
    check("R8 seqErr", seqErr, 1);
    check("R8 videoGo blocked", videoGo, 0);
    wr(3'd3, 5'b00111);
    check("R8 still blocked", videoGo, 0);
    wr(3'd0, 5'd0);
    step();
    check("R4 off again", ifEnable, 0);
    // R9 proper order
    wr(3'd0, 5'd1);
    check("R9 videoGo", videoGo, 1);
    check("R8 sticky", seqErr, 1);

    // R6 wait for response
    pkt(2'd0, 1'b0);
    check("R6 pending", btaPending, 1);
    wr(3'd0, 5'd0);
    repeat (3) step();
    check("R6 waiting", {ifEnable, busy}, 2'b11);
    resp();
    check("R6 cleared", btaPending, 0);
    step();
    check("R6 link dropped", ifEnable, 0);
    check("R7 no timeout", timeoutFlag, 0);

    // R7 timeout
    wr(3'd0, 5'd1);
    pkt(2'd0, 1'b0);
    wr(3'd0, 5'd0);
    repeat (TOUT - 1) step();
    check("R7 not yet", {timeoutFlag, btaPending}, 2'b01);
    step();
    check("R7 flag", timeoutFlag, 1);
    check("R7 pending dropped", btaPending, 0);
    check("R7 link still up", ifEnable, 1);
    step();
    check("R7 link dropped", {ifEnable, busy}, 2'b00);
    repeat (2) step();
    check("R7 sticky", timeoutFlag, 1);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule